// File: doc/BRIEF.md
# Global 64-bit Timer with Periodic Comparator

This block is a memory-mapped system timer. It holds a 64-bit up-counter that advances once per clock while started, and one 64-bit comparator. When the count equals the comparator value, the block latches an event flag. The flag drives a level interrupt if the interrupt is enabled. With auto-increment on, every match adds a programmed 32-bit step to the comparator, so the events repeat at a fixed period without software reloading it.

Software uses a single-cycle 32-bit register port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational while the read strobe is high. The counter keeps running during reads, so a consistent 64-bit value is taken by reading high, low and high again and repeating until both high words agree. Every write to a counter, comparator, step or control register sets a write-done flag in one of two write-status registers. Software clears these flags by writing ones.

Top module: `gct_timer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq` is low.
- R2: While control bit 8 (offset 0x240) is 1, the 64-bit count rises by exactly one per clock, with carry from bit 31 into bit 32. While that bit is 0, the count holds.
- R3: A write to offset 0x100 replaces count bits 31:0, and a write to 0x104 replaces bits 63:32. The other half keeps its value. Reads at these offsets return the matching half.
- R4: Comparator bits 31:0 at 0x200, comparator bits 63:32 at 0x204, the 32-bit step at 0x208 and control at 0x240 all read back what was written. Control keeps only bit 8 (run), bit 1 (auto-increment) and bit 0 (comparator enable); its other bits read zero.
- R5: When the counter is running, the comparator is enabled and the count equals the comparator, bit 0 of the event status (0x244) reads 1 from the next clock edge onward.
- R6: Writing 1 to bit 0 of 0x244 clears the event status. Writing 0 there leaves it unchanged.
- R7: `irq` is high exactly when the event status bit 0 is 1 and bit 0 of the interrupt enable (0x248) is 1.
- R8: With auto-increment set, each match adds the step to the comparator on the same edge that sets the status, so matches repeat every step clocks. With auto-increment clear, the comparator is unchanged by a match.
- R9: No match occurs while the comparator enable is 0 or the counter is stopped, even if the count equals the comparator.
- R10: Write-status register 0x110: bit 0 is set by a write to 0x100, and bit 1 by a write to 0x104. Writing 1 to a bit clears it, and writing 0 leaves it.
- R11: Write-status register 0x24C: bit 0 is set by a write to 0x200, bit 1 by 0x204, bit 2 by 0x208 and bit 16 by 0x240. Writing 1 to a bit clears it. Writes to 0x244, 0x248 and 0x24C set none of these bits.
- R12: Read data is zero when the read strobe is low or the offset is unmapped. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, commits on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, event status AND enable |

## Verification
The hardest situation to reach is the exact clock on which a match fires, because the counter moves on every edge and each register access takes a clock. The bench loads the count and the comparator while the counter is stopped. It then starts the counter with a single control write and counts edges from that point. This places the expected interrupt edge exactly, sweeping over several distances. For auto-increment, it reads the comparator once per clock and predicts its value from the number of matches so far. Carry into the upper word is reached by preloading the low word just below its wrap.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CNT_W  = 2 * BUS_W;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CWS_W  = 2;
  localparam int unsigned GWS_W  = 17;

  typedef logic [BUS_W-1:0]  word_t;
  typedef logic [CNT_W-1:0]  dword_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OFS_CNT_LO = 12'h100;
  localparam addr_t OFS_CNT_HI = 12'h104;
  localparam addr_t OFS_CNT_WS = 12'h110;
  localparam addr_t OFS_CMP_LO = 12'h200;
  localparam addr_t OFS_CMP_HI = 12'h204;
  localparam addr_t OFS_STEP   = 12'h208;
  localparam addr_t OFS_CTL    = 12'h240;
  localparam addr_t OFS_EVT    = 12'h244;
  localparam addr_t OFS_IEN    = 12'h248;
  localparam addr_t OFS_GLB_WS = 12'h24C;

  localparam int unsigned CTL_RUN_BIT  = 8;
  localparam int unsigned CTL_AUTO_BIT = 1;
  localparam int unsigned CTL_CMP_BIT  = 0;

  localparam int unsigned GWS_CMP_LO = 0;
  localparam int unsigned GWS_CMP_HI = 1;
  localparam int unsigned GWS_STEP   = 2;
  localparam int unsigned GWS_CTL    = 16;

  typedef struct packed {
    logic run;
    logic auto_inc;
    logic cmp_en;
  } ctl_t;

  // Replace one half of a double word.
  function automatic dword_t put_half(dword_t cur, word_t w, logic upper);
    return upper ? {w, cur[BUS_W-1:0]} : {cur[CNT_W-1:BUS_W], w};
  endfunction

  function automatic dword_t step_up(dword_t c);
    return c + dword_t'(1);
  endfunction

  function automatic dword_t advance_cmp(dword_t c, word_t step);
    return c + dword_t'(step);
  endfunction

  function automatic word_t ctl_to_word(ctl_t c);
    word_t w;
    w = '0;
    w[CTL_RUN_BIT]  = c.run;
    w[CTL_AUTO_BIT] = c.auto_inc;
    w[CTL_CMP_BIT]  = c.cmp_en;
    return w;
  endfunction
endpackage

// File: rtl/gct_w1c.sv
module gct_w1c #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/gct_counter.sv
module gct_counter
  import gct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  word_t  wdata,
  output dword_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (wr_lo) count <= put_half(count, wdata, 1'b0);
    else if (wr_hi) count <= put_half(count, wdata, 1'b1);
    else if (run)   count <= step_up(count);
  end
endmodule

// File: rtl/gct_comparator.sv
module gct_comparator
  import gct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  logic   wr_step,
  input  word_t  wdata,
  input  dword_t count,
  input  logic   run,
  input  logic   cmp_en,
  input  logic   auto_inc,
  output dword_t cmp,
  output word_t  step,
  output logic   match
);
  assign match = run && cmp_en && (count == cmp);

  // Software writes take priority over the automatic advance.
  always_ff @(posedge clk) begin
    if (!rst_n)                 cmp <= '0;
    else if (wr_lo)             cmp <= put_half(cmp, wdata, 1'b0);
    else if (wr_hi)             cmp <= put_half(cmp, wdata, 1'b1);
    else if (match && auto_inc) cmp <= advance_cmp(cmp, step);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       step <= '0;
    else if (wr_step) step <= wdata;
  end
endmodule

// File: rtl/gct_timer.sv
module gct_timer
  import gct_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [gct_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic [gct_pkg::BUS_W-1:0]  bus_wdata,
  input  logic                       bus_rd,
  output logic [gct_pkg::BUS_W-1:0]  bus_rdata,
  output logic                       irq
);
  // Write strobes
  logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ws, wr_cmp_lo, wr_cmp_hi, wr_step;
  logic wr_ctl, wr_evt, wr_ien, wr_glb_ws;

  assign wr_cnt_lo = bus_wr && (bus_addr == OFS_CNT_LO);
  assign wr_cnt_hi = bus_wr && (bus_addr == OFS_CNT_HI);
  assign wr_cnt_ws = bus_wr && (bus_addr == OFS_CNT_WS);
  assign wr_cmp_lo = bus_wr && (bus_addr == OFS_CMP_LO);
  assign wr_cmp_hi = bus_wr && (bus_addr == OFS_CMP_HI);
  assign wr_step   = bus_wr && (bus_addr == OFS_STEP);
  assign wr_ctl    = bus_wr && (bus_addr == OFS_CTL);
  assign wr_evt    = bus_wr && (bus_addr == OFS_EVT);
  assign wr_ien    = bus_wr && (bus_addr == OFS_IEN);
  assign wr_glb_ws = bus_wr && (bus_addr == OFS_GLB_WS);

  // Internal events brought out by name for the checker
  logic cnt_wr, cmp_wr;
  assign cnt_wr = wr_cnt_lo || wr_cnt_hi;
  assign cmp_wr = wr_cmp_lo || wr_cmp_hi;

  // Control and interrupt enable
  ctl_t ctl_q;
  logic int_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q.run      <= bus_wdata[CTL_RUN_BIT];
      ctl_q.auto_inc <= bus_wdata[CTL_AUTO_BIT];
      ctl_q.cmp_en   <= bus_wdata[CTL_CMP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      int_en_q <= 1'b0;
    else if (wr_ien) int_en_q <= bus_wdata[0];
  end

  logic run_w, auto_w, cmp_en_w;
  assign run_w    = ctl_q.run;
  assign auto_w   = ctl_q.auto_inc;
  assign cmp_en_w = ctl_q.cmp_en;

  // Counter
  dword_t cnt_q;

  gct_counter u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (bus_wdata),
    .count (cnt_q)
  );

  // Comparator
  dword_t cmp_q;
  word_t  inc_q;
  logic   match_w;

  gct_comparator u_comparator (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_cmp_lo),
    .wr_hi    (wr_cmp_hi),
    .wr_step  (wr_step),
    .wdata    (bus_wdata),
    .count    (cnt_q),
    .run      (run_w),
    .cmp_en   (cmp_en_w),
    .auto_inc (auto_w),
    .cmp      (cmp_q),
    .step     (inc_q),
    .match    (match_w)
  );

  // Event status
  logic [0:0] int_sts_q;
  logic [0:0] evt_clr;
  assign evt_clr = wr_evt ? bus_wdata[0:0] : 1'b0;

  gct_w1c #(.W(1)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match_w),
    .clr   (evt_clr),
    .q     (int_sts_q)
  );

  // Counter write status
  logic [CWS_W-1:0] cws_q, cws_set, cws_clr;
  assign cws_set = {wr_cnt_hi, wr_cnt_lo};
  assign cws_clr = wr_cnt_ws ? bus_wdata[CWS_W-1:0] : '0;

  gct_w1c #(.W(CWS_W)) u_cnt_ws (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cws_set),
    .clr   (cws_clr),
    .q     (cws_q)
  );

  // Comparator/control write status
  logic [GWS_W-1:0] gws_q, gws_set, gws_clr;

  always_comb begin
    gws_set             = '0;
    gws_set[GWS_CMP_LO] = wr_cmp_lo;
    gws_set[GWS_CMP_HI] = wr_cmp_hi;
    gws_set[GWS_STEP]   = wr_step;
    gws_set[GWS_CTL]    = wr_ctl;
  end
  assign gws_clr = wr_glb_ws ? bus_wdata[GWS_W-1:0] : '0;

  gct_w1c #(.W(GWS_W)) u_glb_ws (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (gws_set),
    .clr   (gws_clr),
    .q     (gws_q)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CNT_LO: bus_rdata = cnt_q[BUS_W-1:0];
        OFS_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
        OFS_CNT_WS: bus_rdata = word_t'(cws_q);
        OFS_CMP_LO: bus_rdata = cmp_q[BUS_W-1:0];
        OFS_CMP_HI: bus_rdata = cmp_q[CNT_W-1:BUS_W];
        OFS_STEP:   bus_rdata = inc_q;
        OFS_CTL:    bus_rdata = ctl_to_word(ctl_q);
        OFS_EVT:    bus_rdata = word_t'(int_sts_q);
        OFS_IEN:    bus_rdata = word_t'(int_en_q);
        OFS_GLB_WS: bus_rdata = word_t'(gws_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = int_sts_q[0] && int_en_q;
endmodule

// File: rtl/gct_checker.sv
module gct_checker
  import gct_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   run,
  input logic   cnt_wr,
  input dword_t cnt,
  input logic   cmp_wr,
  input dword_t cmp,
  input word_t  incr,
  input logic   match,
  input logic   auto_inc,
  input logic   int_status,
  input logic   irq,
  input logic   bus_rd,
  input word_t  bus_rdata
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt == $past(cnt) + dword_t'(1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_match_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> int_status);

  assert_auto_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_inc && !cmp_wr) |=> (cmp == $past(cmp) + dword_t'($past(incr))));

  assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_status);

  assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

bind gct_timer gct_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_w),
  .cnt_wr     (cnt_wr),
  .cnt        (cnt_q),
  .cmp_wr     (cmp_wr),
  .cmp        (cmp_q),
  .incr       (inc_q),
  .match      (match_w),
  .auto_inc   (auto_w),
  .int_status (int_sts_q[0]),
  .irq        (irq),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata)
);

// File: tb/gct_timer_tb.sv
module gct_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  longint unsigned cyc = 0;
  bit done = 1'b0;

  gct_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Samples shortly after a falling edge; returns at the next falling edge.
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  // High, low, high until the two high words agree; t is the cycle of the low read.
  task automatic rd_cnt(output logic [63:0] v, output longint unsigned t);
    logic [31:0] h1, lo, h2;
    rd(12'h104, h2);
    do begin
      h1 = h2;
      t = cyc;
      rd(12'h100, lo);
      rd(12'h104, h2);
    end while (h1 != h2);
    v = {h1, lo};
  endtask

  task automatic set_cnt(input logic [63:0] v);
    wr(12'h100, v[31:0]);
    wr(12'h104, v[63:32]);
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr(12'h200, v[31:0]);
    wr(12'h204, v[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v, vp;
    longint unsigned t, tp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "irq after reset", {63'b0, irq}, 64'd0);
    foreach (u_addrs_r1[i]) begin
      rd(u_addrs_r1[i], r);
      chk("R1", $sformatf("reg %h after reset", u_addrs_r1[i]), {32'b0, r}, 64'd0);
    end

    // R3 / R10: half writes with the counter stopped
    for (int i = 0; i < 6; i++) begin
      logic [31:0] plo, phi;
      plo = 32'hA5A5_0000 + 32'h1111 * i;
      phi = ~plo ^ (32'h3 << i);
      wr(12'h110, 32'h3);
      wr(12'h100, plo);
      rd(12'h110, r);
      chk("R10", "cnt ws after low write", {32'b0, r}, 64'd1);
      wr(12'h104, phi);
      rd(12'h110, r);
      chk("R10", "cnt ws after high write", {32'b0, r}, 64'd3);
      rd(12'h100, r);
      chk("R3", "low half kept after high write", {32'b0, r}, {32'b0, plo});
      rd(12'h104, r);
      chk("R3", "high half", {32'b0, r}, {32'b0, phi});
      wr(12'h100, ~plo);
      rd(12'h104, r);
      chk("R3", "high half kept after low write", {32'b0, r}, {32'b0, phi});
    end
    wr(12'h110, 32'h0);
    rd(12'h110, r);
    chk("R10", "write 0 leaves cnt ws", {32'b0, r}, 64'd3);
    wr(12'h110, 32'h2);
    rd(12'h110, r);
    chk("R10", "clear bit1 only", {32'b0, r}, 64'd1);

    // R4 / R11: readback and global write status
    wr(12'h24C, 32'h0001_0007);
    wr(12'h200, 32'h1234_5678);
    rd(12'h24C, r);
    chk("R11", "gws after cmp lo", {32'b0, r}, 64'h1);
    wr(12'h204, 32'h9ABC_DEF0);
    rd(12'h24C, r);
    chk("R11", "gws after cmp hi", {32'b0, r}, 64'h3);
    wr(12'h208, 32'h0000_0ABC);
    rd(12'h24C, r);
    chk("R11", "gws after step", {32'b0, r}, 64'h7);
    wr(12'h240, 32'h0000_FEFE);
    rd(12'h24C, r);
    chk("R11", "gws after ctl", {32'b0, r}, 64'h1_0007);
    wr(12'h244, 32'h0);
    wr(12'h248, 32'h0);
    wr(12'h24C, 32'h4);
    rd(12'h24C, r);
    chk("R11", "gws after w1c of bit2", {32'b0, r}, 64'h1_0003);
    rd(12'h200, r);
    chk("R4", "cmp lo", {32'b0, r}, 64'h1234_5678);
    rd(12'h204, r);
    chk("R4", "cmp hi", {32'b0, r}, 64'h9ABC_DEF0);
    rd(12'h208, r);
    chk("R4", "step", {32'b0, r}, 64'h0ABC);
    rd(12'h240, r);
    chk("R4", "ctl keeps bits 8,1,0 only", {32'b0, r}, 64'h2);
    wr(12'h240, 32'h0);

    // R12: unmapped offsets and idle read
    foreach (u_addrs_r12[i]) begin
      rd(u_addrs_r12[i], r);
      chk("R12", $sformatf("unmapped %h", u_addrs_r12[i]), {32'b0, r}, 64'd0);
    end
    bus_addr = 12'h200; #1;
    chk("R12", "idle read data", {32'b0, bus_rdata}, 64'd0);
    @(negedge clk);

    // R2: running count across the word carry, read while running
    set_cnt(64'h0000_0007_FFFF_FFF0);
    wr(12'h240, 32'h100);
    rd_cnt(vp, tp);
    for (int i = 0; i < 12; i++) begin
      rd_cnt(v, t);
      chk("R2", "count advance equals elapsed clocks", v - vp, t - tp);
      vp = v; tp = t;
    end
    chk("R2", "carry into high word", {32'b0, v[63:32]}, 64'd8);
    wr(12'h240, 32'h0);
    rd_cnt(vp, tp);
    repeat (5) @(negedge clk);
    rd_cnt(v, t);
    chk("R2", "count holds when stopped", v, vp);

    // R5 / R6 / R7 / R8: exact match timing sweep, auto-increment off
    wr(12'h248, 32'h1);
    for (int d = 1; d <= 6; d++) begin
      logic [31:0] base;
      base = 32'h100 * d;
      wr(12'h240, 32'h0);
      wr(12'h244, 32'h1);
      set_cnt({32'h0, base});
      set_cmp({32'h0, base + d});
      wr(12'h240, 32'h101);
      for (int k = 1; k <= d + 2; k++) begin
        @(negedge clk);
        chk("R5", $sformatf("irq d=%0d edge %0d", d, k), {63'b0, irq},
            (k >= d + 1) ? 64'd1 : 64'd0);
      end
      rd(12'h244, r);
      chk("R5", "status after match", {32'b0, r}, 64'd1);
      rd(12'h200, r);
      chk("R8", "cmp unchanged without auto", {32'b0, r}, {32'b0, base + d});
      wr(12'h244, 32'h0);
      rd(12'h244, r);
      chk("R6", "write 0 keeps status", {32'b0, r}, 64'd1);
      wr(12'h244, 32'h1);
      rd(12'h244, r);
      chk("R6", "write 1 clears status", {32'b0, r}, 64'd0);
      chk("R7", "irq low after clear", {63'b0, irq}, 64'd0);
    end

    // R7: enable gates irq
    wr(12'h240, 32'h0);
    wr(12'h248, 32'h0);
    wr(12'h244, 32'h1);
    set_cnt(64'h50);
    set_cmp(64'h52);
    wr(12'h240, 32'h101);
    repeat (5) @(negedge clk);
    rd(12'h244, r);
    chk("R7", "status set with enable off", {32'b0, r}, 64'd1);
    chk("R7", "irq low with enable off", {63'b0, irq}, 64'd0);
    wr(12'h248, 32'h1);
    chk("R7", "irq high once enabled", {63'b0, irq}, 64'd1);

    // R9: comparator disabled, then counter stopped
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    set_cnt(64'h10);
    set_cmp(64'h14);
    wr(12'h240, 32'h100);
    repeat (10) @(negedge clk);
    rd(12'h244, r);
    chk("R9", "no match with comparator disabled", {32'b0, r}, 64'd0);
    wr(12'h240, 32'h0);
    set_cnt(64'h14);
    wr(12'h240, 32'h001);
    repeat (3) @(negedge clk);
    rd(12'h244, r);
    chk("R9", "no match with counter stopped", {32'b0, r}, 64'd0);
    chk("R9", "irq low with counter stopped", {63'b0, irq}, 64'd0);

    // R8: periodic auto-increment sweep
    foreach (u_steps_r8[j]) begin
      int p, k, nd;
      p = u_steps_r8[j];
      wr(12'h240, 32'h0);
      set_cnt(64'h0);
      set_cmp(64'd10);
      wr(12'h208, p);
      wr(12'h244, 32'h1);
      wr(12'h240, 32'h103);
      k = 0;
      while (k < 10 + 4 * p + 2) begin
        nd = (k >= 11) ? ((k - 11) / p + 1) : 0;
        rd(12'h200, r);
        chk("R8", $sformatf("cmp p=%0d edge %0d", p, k), {32'b0, r}, 64'(10 + p * nd));
        k++;
      end
      rd(12'h240, r);
      chk("R4", "ctl readback all bits", {32'b0, r}, 64'h103);
      chk("R8", "irq after periodic match", {63'b0, irq}, 64'd1);
      wr(12'h244, 32'h1);
      repeat (p + 1) @(negedge clk);
      chk("R8", "irq reasserts within one period", {63'b0, irq}, 64'd1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [11:0] u_addrs_r1 [10] = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
                                   12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};
  logic [11:0] u_addrs_r12 [7] = '{12'h000, 12'h108, 12'h10C, 12'h20C,
                                   12'h250, 12'h300, 12'hFFC};
  int u_steps_r8 [3] = '{3, 5, 8};
endmodule